// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a virtual page number into a final page table entry by fetching two table entries from memory, one after the other. A requester presents a 20-bit virtual page number while the walker is idle; the walker captures it together with the base address of the master table. It then reads the master entry, which locates a secondary table, and reads the secondary entry, which describes the physical frame.

Each lookup is a single 32-bit word read on a simple strobe/data-valid memory port. The memory may take any number of cycles to answer. An entry whose valid flag is clear ends the walk at once with a fault, and the fault says which of the two levels stopped it. The master table is always resident, so reading it never faults; only its contents can. The result is held until the requester acknowledges it. Only one walk is in flight at a time.

Top module: `pt_walker`

## Requirements
- R1: The upper 10 bits of the page number, `req_vpn_i[19:10]`, index the master table, and the lower 10 bits, `req_vpn_i[9:0]`, index the secondary table.
- R2: The first read goes to the captured master base plus 4 times the master index; `mem_req_o` stays high with a steady `mem_addr_o` until `mem_rvalid_i` is seen.
- R3: Bit 0 of an entry is its valid flag; a master entry with bit 0 clear ends the walk with `rsp_fault_o`=1, `rsp_level_o`=0, and no second read.
- R4: For a valid master entry, the second read goes to `{entry[31:12], 12'h000}` plus 4 times the secondary index.
- R5: A secondary entry with bit 0 clear ends the walk with `rsp_fault_o`=1 and `rsp_level_o`=1.
- R6: A secondary entry with bit 0 set ends the walk with `rsp_fault_o`=0 and `rsp_pte_o` equal to that entry.
- R7: `req_ready_o` is high only while no walk is active; the page number and master base are captured when `req_valid_i` and `req_ready_o` are both high, and later changes to them do not affect that walk.
- R8: `rsp_valid_o`, `rsp_pte_o`, `rsp_fault_o` and `rsp_level_o` hold steady until `rsp_ack_i` is high; the cycle after the acknowledgement `req_ready_o` is high again.
- R9: A `mem_rvalid_i` pulse while `mem_req_o` is low changes nothing.
- R10: After reset, `req_ready_o`=1, `mem_req_o`=0 and `rsp_valid_o`=0.
- R11: A memory answer is accepted at any latency, including in the first cycle the read is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Walk request present |
| req_vpn_i | input | 20 | Virtual page number to translate |
| root_base_i | input | 32 | Byte address of the master table |
| req_ready_o | output | 1 | Walker idle, request will be taken |
| mem_req_o | output | 1 | Read strobe, held until answered |
| mem_addr_o | output | 32 | Byte address of the entry being read |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | 32 | Read data |
| rsp_valid_o | output | 1 | Result present |
| rsp_pte_o | output | 32 | Entry that ended the walk |
| rsp_fault_o | output | 1 | Walk ended on an invalid entry |
| rsp_level_o | output | 1 | Faulting level: 0 master, 1 secondary |
| rsp_ack_i | input | 1 | Requester has taken the result |

## Verification
The acknowledgement of one result and the arrival of the next request can fall in the same cycle; the bench raises `rsp_ack_i` and `req_valid_i` together and checks that the new request is only taken one cycle later, once `req_ready_o` is back, with its own page number. A stray `mem_rvalid_i` can coincide with a held result or with idle time; the bench injects such pulses and a clock-by-clock reference model confirms that no output moves. Memory latencies of zero to seven cycles, and changes to the page number and base during a walk, are judged the same way.

// File: rtl/pt_walker_pkg.sv
package pt_walker_pkg;
  typedef enum logic [1:0] {
    WLK_IDLE = 2'd0,
    WLK_MST  = 2'd1,
    WLK_SEC  = 2'd2,
    WLK_RSP  = 2'd3
  } walk_state_e;

  typedef enum logic {
    LVL_MASTER = 1'b0,
    LVL_SECOND = 1'b1
  } walk_lvl_e;
endpackage

// File: rtl/pt_idx_split.sv
module pt_idx_split #(
  parameter int VPN_W = 20,
  parameter int IDX_W = 10
) (
  input  logic [VPN_W-1:0] vpn_i,
  output logic [IDX_W-1:0] idx_mst_o,
  output logic [IDX_W-1:0] idx_sec_o
);
  assign idx_mst_o = vpn_i[VPN_W-1 -: IDX_W];
  assign idx_sec_o = vpn_i[IDX_W-1:0];
endmodule

// File: rtl/pt_entry_addr.sv
module pt_entry_addr #(
  parameter int ADDR_W    = 32,
  parameter int IDX_W     = 10,
  parameter int PTE_SHIFT = 2
) (
  input  logic [ADDR_W-1:0] base_i,
  input  logic [IDX_W-1:0]  idx_i,
  output logic [ADDR_W-1:0] addr_o
);
  localparam int OFS_W = IDX_W + PTE_SHIFT;
  logic [OFS_W-1:0] ofs;
  assign ofs    = {idx_i, {PTE_SHIFT{1'b0}}};
  assign addr_o = base_i + ADDR_W'(ofs);
endmodule

// File: rtl/pt_walk_ctrl.sv
module pt_walk_ctrl
  import pt_walker_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int PAGE_OFF_W = 12,
  parameter int VPN_W      = 20,
  parameter int VALID_BIT  = 0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [VPN_W-1:0]  req_vpn_i,
  input  logic [ADDR_W-1:0] root_base_i,
  input  logic              mem_rvalid_i,
  input  logic [ADDR_W-1:0] mem_rdata_i,
  input  logic              rsp_ack_i,
  output walk_state_e       state_o,
  output logic [VPN_W-1:0]  vpn_o,
  output logic [ADDR_W-1:0] tbl_base_o,
  output logic [ADDR_W-1:0] pte_o,
  output logic              fault_o,
  output walk_lvl_e         lvl_o
);
  walk_state_e       state_q;
  logic [VPN_W-1:0]  vpn_q;
  logic [ADDR_W-1:0] tbl_q, pte_q;
  logic              fault_q;
  walk_lvl_e         lvl_q;
  logic              ent_ok;

  assign ent_ok = mem_rdata_i[VALID_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= WLK_IDLE;
      vpn_q   <= '0;
      tbl_q   <= '0;
      pte_q   <= '0;
      fault_q <= 1'b0;
      lvl_q   <= LVL_MASTER;
    end else begin
      unique case (state_q)
        WLK_IDLE: if (req_valid_i) begin
          vpn_q   <= req_vpn_i;
          tbl_q   <= root_base_i;
          state_q <= WLK_MST;
        end
        WLK_MST: if (mem_rvalid_i) begin
          if (ent_ok) begin
            tbl_q   <= {mem_rdata_i[ADDR_W-1:PAGE_OFF_W], {PAGE_OFF_W{1'b0}}};
            state_q <= WLK_SEC;
          end else begin
            pte_q   <= mem_rdata_i;
            fault_q <= 1'b1;
            lvl_q   <= LVL_MASTER;
            state_q <= WLK_RSP;
          end
        end
        WLK_SEC: if (mem_rvalid_i) begin
          pte_q   <= mem_rdata_i;
          fault_q <= ~ent_ok;
          lvl_q   <= LVL_SECOND;
          state_q <= WLK_RSP;
        end
        WLK_RSP: if (rsp_ack_i) state_q <= WLK_IDLE;
        default: state_q <= WLK_IDLE;
      endcase
    end
  end

  assign state_o    = state_q;
  assign vpn_o      = vpn_q;
  assign tbl_base_o = tbl_q;
  assign pte_o      = pte_q;
  assign fault_o    = fault_q;
  assign lvl_o      = lvl_q;
endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import pt_walker_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int PAGE_OFF_W = 12,
  parameter int IDX_W      = 10,
  parameter int PTE_BYTES  = 4,
  parameter int VALID_BIT  = 0,
  localparam int VPN_W     = ADDR_W - PAGE_OFF_W,
  localparam int PTE_SHIFT = $clog2(PTE_BYTES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [VPN_W-1:0]  req_vpn_i,
  input  logic [ADDR_W-1:0] root_base_i,
  output logic              req_ready_o,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic              mem_rvalid_i,
  input  logic [ADDR_W-1:0] mem_rdata_i,
  output logic              rsp_valid_o,
  output logic [ADDR_W-1:0] rsp_pte_o,
  output logic              rsp_fault_o,
  output logic              rsp_level_o,
  input  logic              rsp_ack_i
);
  walk_state_e       state;
  walk_lvl_e         lvl;
  logic [VPN_W-1:0]  vpn;
  logic [ADDR_W-1:0] tbl_base;
  logic [IDX_W-1:0]  idx_mst, idx_sec, idx_cur;

  pt_walk_ctrl #(
    .ADDR_W(ADDR_W), .PAGE_OFF_W(PAGE_OFF_W), .VPN_W(VPN_W), .VALID_BIT(VALID_BIT)
  ) u_ctrl (
    .clk_i, .rst_ni, .req_valid_i, .req_vpn_i, .root_base_i,
    .mem_rvalid_i, .mem_rdata_i, .rsp_ack_i,
    .state_o(state), .vpn_o(vpn), .tbl_base_o(tbl_base),
    .pte_o(rsp_pte_o), .fault_o(rsp_fault_o), .lvl_o(lvl)
  );

  pt_idx_split #(.VPN_W(VPN_W), .IDX_W(IDX_W)) u_split (
    .vpn_i(vpn), .idx_mst_o(idx_mst), .idx_sec_o(idx_sec)
  );

  assign idx_cur = (state == WLK_SEC) ? idx_sec : idx_mst;

  pt_entry_addr #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .PTE_SHIFT(PTE_SHIFT)) u_addr (
    .base_i(tbl_base), .idx_i(idx_cur), .addr_o(mem_addr_o)
  );

  assign req_ready_o = (state == WLK_IDLE);
  assign mem_req_o   = (state == WLK_MST) || (state == WLK_SEC);
  assign rsp_valid_o = (state == WLK_RSP);
  assign rsp_level_o = lvl;
endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic              req_ready_o,
  input logic              mem_req_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              mem_rvalid_i,
  input logic [ADDR_W-1:0] mem_rdata_i,
  input logic              rsp_valid_o,
  input logic [ADDR_W-1:0] rsp_pte_o,
  input logic              rsp_fault_o,
  input logic              rsp_level_o,
  input logic              rsp_ack_i
);
  logic chk_lvl; // 0: next answer is master, 1: secondary
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chk_lvl <= 1'b0;
    else if (req_valid_i && req_ready_o) chk_lvl <= 1'b0;
    else if (mem_req_o && mem_rvalid_i) chk_lvl <= 1'b1;
  end

  assert_ready_excl_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> !mem_req_o && !rsp_valid_o);

  assert_addr_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_rvalid_i |=> mem_req_o && $stable(mem_addr_o));

  assert_mst_fault_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_rvalid_i && !mem_rdata_i[0] && !chk_lvl
    |=> rsp_valid_o && rsp_fault_o && !rsp_level_o);

  assert_sec_fault_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_rvalid_i && !mem_rdata_i[0] && chk_lvl
    |=> rsp_valid_o && rsp_fault_o && rsp_level_o);

  assert_sec_ok_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_rvalid_i && mem_rdata_i[0] && chk_lvl
    |=> rsp_valid_o && !rsp_fault_o && rsp_pte_o == $past(mem_rdata_i));

  assert_rsp_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && !rsp_ack_i |=> rsp_valid_o && $stable(rsp_pte_o)
      && $stable(rsp_fault_o) && $stable(rsp_level_o));

  assert_ack_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && rsp_ack_i |=> req_ready_o);

  assert_stray_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_req_o && !req_valid_i && !rsp_ack_i |=> $stable(req_ready_o) && $stable(rsp_valid_o));
endmodule

bind pt_walker pt_walker_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_valid_i(req_valid_i), .req_ready_o(req_ready_o),
  .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o), .mem_rvalid_i(mem_rvalid_i),
  .mem_rdata_i(mem_rdata_i), .rsp_valid_o(rsp_valid_o), .rsp_pte_o(rsp_pte_o),
  .rsp_fault_o(rsp_fault_o), .rsp_level_o(rsp_level_o), .rsp_ack_i(rsp_ack_i)
);

// File: tb/pt_walker_tb.sv
`timescale 1ns/1ps
module pt_walker_tb;
  logic        clk = 0, rst_ni = 0;
  logic        req_valid = 0, rsp_ack = 0, mem_rvalid = 0;
  logic [19:0] req_vpn = '0;
  logic [31:0] root_base = '0, mem_rdata = '0;
  logic        req_ready, mem_req, rsp_valid, rsp_fault, rsp_level;
  logic [31:0] mem_addr, rsp_pte;

  int errors = 0, checks = 0, cycles = 0;
  int lat = 1, cnt = 0;
  bit stray_req = 0;
  logic [31:0] mem [logic [31:0]];

  always #10 clk = ~clk;

  pt_walker u_dut (
    .clk_i(clk), .rst_ni, .req_valid_i(req_valid), .req_vpn_i(req_vpn),
    .root_base_i(root_base), .req_ready_o(req_ready), .mem_req_o(mem_req),
    .mem_addr_o(mem_addr), .mem_rvalid_i(mem_rvalid), .mem_rdata_i(mem_rdata),
    .rsp_valid_o(rsp_valid), .rsp_pte_o(rsp_pte), .rsp_fault_o(rsp_fault),
    .rsp_level_o(rsp_level), .rsp_ack_i(rsp_ack)
  );

  function automatic logic [31:0] rd(input logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h at cycle %0d", rq, act, exp, cycles);
    end
  endtask

  // memory responder: one pulse per read after lat negedges, plus injected strays
  always @(negedge clk) begin
    if (mem_rvalid) begin
      mem_rvalid <= 0; cnt <= 0;
    end else if (stray_req) begin
      mem_rvalid <= 1; mem_rdata <= 32'hDEAD_B001; stray_req <= 0;
    end else if (mem_req) begin
      if (cnt >= lat) begin
        mem_rvalid <= 1; mem_rdata <= rd(mem_addr); cnt <= 0;
      end else cnt <= cnt + 1;
    end
  end

  // behavioural reference model
  int          m_st = 0;
  logic [19:0] m_vpn;
  logic [31:0] m_base, m_sec, m_pte;
  bit          m_fault, m_lvl;

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) m_st = 0;
    else case (m_st)
      0: if (req_valid) begin m_vpn = req_vpn; m_base = root_base; m_st = 1; end
      1: if (mem_rvalid) begin
           if (mem_rdata[0]) begin m_sec = mem_rdata & 32'hFFFF_F000; m_st = 2; end
           else begin m_pte = mem_rdata; m_fault = 1; m_lvl = 0; m_st = 3; end
         end
      2: if (mem_rvalid) begin m_pte = mem_rdata; m_fault = !mem_rdata[0]; m_lvl = 1; m_st = 3; end
      default: if (rsp_ack) m_st = 0;
    endcase
  end

  always @(negedge clk) begin
    if (rst_ni) begin
      cycles++;
      chk("R7 req_ready", req_ready, m_st == 0);
      chk("R2 mem_req", mem_req, m_st == 1 || m_st == 2);
      chk("R8 rsp_valid", rsp_valid, m_st == 3);
      if (m_st == 1) chk("R1/R2 master addr", mem_addr, m_base + 32'(m_vpn[19:10]) * 4);
      if (m_st == 2) chk("R1/R4 second addr", mem_addr, m_sec + 32'(m_vpn[9:0]) * 4);
      if (m_st == 3) begin
        chk("R6 rsp_pte", rsp_pte, m_pte);
        chk("R3/R5 rsp_fault", rsp_fault, m_fault);
        if (m_fault) chk("R3/R5 rsp_level", rsp_level, m_lvl);
      end
    end
    if (cycles > 20000) begin
      errors++;
      $display("FAIL watchdog act=%0d exp<=20000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  // direct expectation from the tables
  task automatic expect_walk(input logic [19:0] vpn, input logic [31:0] base,
                             output logic [31:0] pte, output bit flt, output bit lvl);
    logic [31:0] me;
    me = rd(base + 32'(vpn[19:10]) * 4);
    if (!me[0]) begin pte = me; flt = 1; lvl = 0; return; end
    pte = rd({me[31:12], 12'h0} + 32'(vpn[9:0]) * 4);
    flt = !pte[0]; lvl = 1;
  endtask

  task automatic walk(input logic [19:0] vpn, input logic [31:0] base, input int l,
                      input int hold, input bit scramble, input bit stray, input string rq);
    logic [31:0] ep; bit ef, el;
    expect_walk(vpn, base, ep, ef, el);
    lat = l;
    @(negedge clk);
    req_valid = 1; req_vpn = vpn; root_base = base;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 0;
    if (scramble) begin req_vpn = ~vpn; root_base = 32'h00F0_0000; end
    while (!rsp_valid) @(negedge clk);
    for (int i = 0; i < hold; i++) begin
      if (stray && i == 0) begin @(posedge clk); stray_req = 1; end
      @(negedge clk);
    end
    chk({rq, " pte"}, rsp_pte, ep);
    chk({rq, " fault"}, rsp_fault, ef);
    if (ef) chk({rq, " level"}, rsp_level, el);
    rsp_ack = 1;
    @(negedge clk);
    rsp_ack = 0;
    chk("R8 ready after ack", req_ready, 1);
  endtask

  initial begin
    mem[32'h0001_0000 + 5*4]    = 32'h0002_0001;
    mem[32'h0002_0000 + 7*4]    = 32'hABCD_E003;
    mem[32'h0002_0000 + 8*4]    = 32'hABCD_E002;
    mem[32'h0001_0000 + 6*4]    = 32'h0000_0000;
    mem[32'h0001_0000 + 1023*4] = 32'h0003_0FF1;
    mem[32'h0003_0000 + 1023*4] = 32'h1234_5001;
    mem[32'h0001_0000]          = 32'h0004_0001;
    mem[32'h0004_0000]          = 32'h7777_7001;
    mem[32'h0005_0000 + 5*4]    = 32'h0004_0001;
    mem[32'h0004_0000 + 9*4]    = 32'h5555_5001;

    #35;
    chk("R10 reset ready", req_ready, 1);
    chk("R10 reset mem_req", mem_req, 0);
    chk("R10 reset rsp_valid", rsp_valid, 0);
    rst_ni = 1;

    walk({10'd5, 10'd7}, 32'h0001_0000, 1, 0, 0, 0, "R6 ok");
    walk({10'd5, 10'd8}, 32'h0001_0000, 2, 0, 0, 0, "R5 sec fault");
    walk({10'd6, 10'd3}, 32'h0001_0000, 0, 0, 0, 0, "R3 mst fault");
    walk({10'd1023, 10'd1023}, 32'h0001_0000, 3, 0, 0, 0, "R1 top idx");
    walk({10'd0, 10'd0}, 32'h0001_0000, 0, 0, 0, 0, "R11 lat0");
    walk({10'd5, 10'd7}, 32'h0001_0000, 7, 4, 0, 0, "R11 lat7 R8 hold");
    walk({10'd5, 10'd9}, 32'h0005_0000, 2, 0, 1, 0, "R7 capture");
    walk({10'd5, 10'd7}, 32'h0001_0000, 1, 3, 0, 1, "R9 stray in rsp");

    // stray answer while idle
    @(posedge clk); stray_req = 1;
    repeat (3) @(negedge clk);
    chk("R9 idle stray ready", req_ready, 1);
    chk("R9 idle stray rsp", rsp_valid, 0);

    // ack and new request in the same cycle
    lat = 1;
    @(negedge clk); req_valid = 1; req_vpn = {10'd5, 10'd8}; root_base = 32'h0001_0000;
    @(negedge clk); req_valid = 0;
    while (!rsp_valid) @(negedge clk);
    rsp_ack = 1; req_valid = 1; req_vpn = {10'd5, 10'd7};
    @(negedge clk);
    rsp_ack = 0;
    chk("R7 ready after ack", req_ready, 1);
    @(negedge clk);
    req_valid = 0;
    chk("R7 taken after idle", mem_req, 1);
    while (!rsp_valid) @(negedge clk);
    chk("R6 back-to-back pte", rsp_pte, 32'hABCD_E003);
    chk("R6 back-to-back fault", rsp_fault, 0);
    rsp_ack = 1; @(negedge clk); rsp_ack = 0;

    repeat (3) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule